// File: doc/BRIEF.md
# Dual-Mode Biphase Line Encoder

This block turns a serial bit stream into a self-clocking two-level line code. Each bit occupies two cycles of the block clock, a first half and a second half. A one-bit mode input picks between FM0 (biphase-space) coding and Manchester coding. Both codes run on one datapath: a single state flip-flop holds the FM0 line level, and one XOR stage forms both codes. It combines a level source with a flip term taken from the current half-bit phase.

A producer presents a bit, its mode and a valid strobe before the clock edge that opens a bit period. The encoder samples them only on that edge. It drives the coded level from a register for the two halves that follow. When no bit is offered at a boundary, the line rests low for that bit period, output-valid is low, and the FM0 level is kept for the next coded bit.

Top module: `line_enc_top`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) drives `line_out` low and `line_valid` low. It clears the FM0 level to 0 and places the next clock edge at a bit boundary, so the first coded FM0 bit after reset starts high.
- R2: `in_valid`, `in_bit` and `in_mode` are sampled only at a bit boundary; changing them during the second half of a bit has no effect on that bit's output.
- R3: In FM0 mode (`in_mode` = 0) the output level inverts at the start of every coded bit, relative to the level the line held before it.
- R4: In FM0 mode a data 0 inverts the level again at mid-bit, while a data 1 keeps the same level for both halves.
- R5: In Manchester mode (`in_mode` = 1) the first half carries the data bit and the second half its inverse (data 1 is high then low), so the level changes at every mid-bit.
- R6: The mode takes effect at the next bit boundary. Manchester bits leave the FM0 level untouched, so FM0 coding resumes from the level the last FM0 bit left.
- R7: When `in_valid` is low at a bit boundary, `line_valid` is low and `line_out` is low for both halves of that bit, and the FM0 level is held.
- R8: The first half of a bit appears on `line_out` one clock after the boundary edge that sampled it and lasts one clock; boundary and mid-bit edges alternate on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-bit clock; one bit spans two cycles |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A bit is offered at this boundary |
| in_bit | input | 1 | Data bit to code |
| in_mode | input | 1 | 0 = FM0, 1 = Manchester |
| line_out | output | 1 | Registered coded line level |
| line_valid | output | 1 | High while `line_out` carries a coded bit |

## Verification
The boundary edge loads a new bit and applies the FM0 start-of-bit inversion in the same cycle that the mode select may switch codes. A mode change and a valid strobe can therefore meet the shared XOR stage together with the FM0 level left by an earlier bit. The vector walk switches between FM0 and Manchester on adjacent bits, and sets idle gaps between them. The expected level after each switch is derived from the FM0 level the bench's own arithmetic carried across the Manchester and idle bits. Each bit's second half is sampled after the bench has flipped every input, so a stray mid-bit sample shows up as a wrong level.

// File: rtl/line_enc_pkg.sv
package line_enc_pkg;

    typedef enum logic {
        CODE_FM0 = 1'b0,
        CODE_MAN = 1'b1
    } code_e;

    typedef struct packed {
        code_e mode;   // code of the bit in flight
        logic  bit_v;  // data bit in flight
        logic  lvl;    // FM0 line level (the one state flip-flop)
        logic  out;    // registered line level
        logic  valid;  // a coded bit is on the line
    } enc_state_t;

endpackage

// File: rtl/line_enc_phase.sv
module line_enc_phase (
    input  logic clk,
    input  logic rst,
    output logic second_o
);
    logic second_d, second_q;

    always_comb begin
        second_d = !second_q;
    end

    always_ff @(posedge clk) begin
        if (rst) second_q <= 1'b0;
        else     second_q <= second_d;
    end

    assign second_o = second_q;

    // R8: boundary and mid-bit edges alternate
    a_r8_phase_alternates: assert property (@(posedge clk) disable iff (rst)
        second_q |=> !second_q);
    a_r8_phase_alternates_b: assert property (@(posedge clk) disable iff (rst)
        !second_q |=> second_q);
endmodule

// File: rtl/line_enc_xor.sv
module line_enc_xor
    import line_enc_pkg::*;
(
    input  code_e mode_i,
    input  logic  second_i,  // computing the second half of a bit
    input  logic  bit_i,
    input  logic  lvl_i,
    output logic  level_o
);
    logic src, flip;

    always_comb begin
        if (mode_i == CODE_MAN) begin
            src  = bit_i;
            flip = second_i;
        end else begin
            src  = lvl_i;
            flip = second_i ? !bit_i : 1'b1;
        end
        level_o = src ^ flip;
    end
endmodule

// File: rtl/line_enc_top.sv
module line_enc_top
    import line_enc_pkg::*;
#(
    parameter logic IDLE_LEVEL = 1'b0,
    parameter logic FM0_INIT   = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic in_bit,
    input  logic in_mode,
    output logic line_out,
    output logic line_valid
);
    enc_state_t st_d, st_q;
    logic  second_q;
    logic  cur_active, cur_bit, coded;
    code_e cur_mode;

    line_enc_phase u_phase (
        .clk      (clk),
        .rst      (rst),
        .second_o (second_q)
    );

    always_comb begin
        if (second_q) begin
            cur_active = st_q.valid;
            cur_bit    = st_q.bit_v;
            cur_mode   = st_q.mode;
        end else begin
            cur_active = in_valid;
            cur_bit    = in_bit;
            cur_mode   = code_e'(in_mode);
        end
    end

    line_enc_xor u_xor (
        .mode_i   (cur_mode),
        .second_i (second_q),
        .bit_i    (cur_bit),
        .lvl_i    (st_q.lvl),
        .level_o  (coded)
    );

    always_comb begin
        st_d       = st_q;
        st_d.mode  = cur_mode;
        st_d.bit_v = cur_bit;
        st_d.valid = cur_active;
        st_d.out   = cur_active ? coded : IDLE_LEVEL;
        if (cur_active && cur_mode == CODE_FM0) begin
            st_d.lvl = coded;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.mode  <= CODE_FM0;
            st_q.bit_v <= 1'b0;
            st_q.lvl   <= FM0_INIT;
            st_q.out   <= IDLE_LEVEL;
            st_q.valid <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign line_out   = st_q.out;
    assign line_valid = st_q.valid;

    // R3: a coded FM0 bit following an FM0 bit starts by inverting the line
    a_r3_fm0_start_inverts: assert property (@(posedge clk) disable iff (rst)
        (!second_q && in_valid && in_mode == CODE_FM0 && line_valid && st_q.mode == CODE_FM0)
        |=> (line_out != $past(line_out)));
    // R4: an FM0 data 1 holds its level across mid-bit
    a_r4_fm0_one_holds: assert property (@(posedge clk) disable iff (rst)
        (second_q && line_valid && st_q.mode == CODE_FM0 && st_q.bit_v)
        |=> $stable(line_out));
    // R5: Manchester always changes level at mid-bit
    a_r5_man_mid_transition: assert property (@(posedge clk) disable iff (rst)
        (second_q && line_valid && st_q.mode == CODE_MAN)
        |=> (line_out != $past(line_out)));
    // R7: no bit offered at a boundary gives an idle, invalid line and a kept FM0 level
    a_r7_idle_line: assert property (@(posedge clk) disable iff (rst)
        (!second_q && !in_valid) |=> (!line_valid && line_out == IDLE_LEVEL));
    a_r7_fm0_level_held: assert property (@(posedge clk) disable iff (rst)
        (!second_q && !in_valid) |=> (st_q.lvl == $past(st_q.lvl)));
    // R6: Manchester bits leave the FM0 level untouched
    a_r6_man_keeps_level: assert property (@(posedge clk) disable iff (rst)
        (!second_q && in_valid && in_mode == CODE_MAN) |=> (st_q.lvl == $past(st_q.lvl)));
endmodule

// File: tb/tb_line_enc_top.sv
module tb_line_enc_top;
    logic clk = 1'b0;
    logic rst, in_valid, in_bit, in_mode;
    logic line_out, line_valid;
    int   n_run  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    always #10 clk = !clk;  // 50 MHz

    line_enc_top dut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_bit     (in_bit),
        .in_mode    (in_mode),
        .line_out   (line_out),
        .line_valid (line_valid)
    );

    // {valid, bit, mode, exp_first, exp_second, exp_valid}; mode 1 = Manchester
    localparam int NV = 16;
    localparam logic [5:0] VEC [NV] = '{
        6'b110_111, // FM0 1 from reset level 0            R3 R4
        6'b100_011, // FM0 0                               R4
        6'b100_011, // FM0 0                               R4
        6'b110_001, // FM0 1                               R4
        6'b111_101, // Manchester 1                        R5
        6'b101_011, // Manchester 0                        R5
        6'b000_000, // idle                                R7
        6'b100_101, // FM0 0 after idle, level 0           R6 R7
        6'b110_111, // FM0 1
        6'b101_011, // Manchester 0, FM0 level stays 1     R6
        6'b110_001, // FM0 1 resumes from level 1          R6
        6'b010_000, // idle with bit set                   R7
        6'b110_111, // FM0 1
        6'b111_101, // Manchester 1
        6'b001_000, // idle, level 1 held                  R7
        6'b110_001  // FM0 1 from held level 1             R7
    };

    task automatic check(input logic act, input logic exp, input string what);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", what, act, exp);
        end
    endtask

    // Called at a negedge just before a boundary edge.
    task automatic run_bit(input logic v, input logic b, input logic m,
                           input logic ef, input logic es, input logic ev,
                           input string tag);
        in_valid = v; in_bit = b; in_mode = m;
        @(posedge clk);
        @(negedge clk);
        check(line_out,   ef, {tag, " first half level (R8)"});
        check(line_valid, ev, {tag, " first half valid"});
        in_valid = !v; in_bit = !b; in_mode = !m;  // R2: mid-bit changes ignored
        @(posedge clk);
        @(negedge clk);
        check(line_out,   es, {tag, " second half level (R2)"});
        check(line_valid, ev, {tag, " second half valid (R2)"});
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_bit = 1'b0; in_mode = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(line_out,   1'b0, "R1 reset line level");
        check(line_valid, 1'b0, "R1 reset valid");
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = !VEC[i][5] ? "R7 idle" : (VEC[i][3] ? "R5 manchester" : "R4 fm0");
            if (i == 0)  tag = "R3 fm0 first after reset";
            if (i == 10) tag = "R6 fm0 after manchester";
            run_bit(VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0],
                    $sformatf("%s vec %0d", tag, i));
        end

        // Leave FM0 level at 1, then reset mid-stream.
        run_bit(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, "R3 fm0 before reset");
        rst = 1'b1; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(line_out,   1'b0, "R1 reset mid-stream level");
        check(line_valid, 1'b0, "R1 reset mid-stream valid");
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        run_bit(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R1 idle after reset");
        run_bit(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, "R1 fm0 level cleared");
        run_bit(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R3 fm0 zero");
        run_bit(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R5 manchester zero");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule